// File: doc/BRIEF.md
# Linked Descriptor Scatter-Gather Walker

This block turns a chain of 16-byte memory descriptors into a sequence of DMA segment requests. Software places descriptors in memory, each naming a buffer address, a length in 8-byte units, a direction, an ordering hint, a transfer mode and a link to the next descriptor. A single start pulse hands the walker the address of the first descriptor. The walker then fetches descriptors one at a time over a read port, offers one segment per descriptor to a data mover through a valid/ready handshake, and follows the links until it reaches a descriptor flagged as the final one.

A descriptor is laid out little-endian in the 128-bit read response. Bits 31:0 hold the buffer address and bits 63:32 hold the length count. Bits 71:64 hold the flag byte and bits 79:72 hold the mode byte. Bits 95:80 are not used by the walker, and bits 127:96 hold the link to the next descriptor. The walker checks 8-byte alignment of the pointers it is given. A descriptor with a zero length is skipped without a segment. The walk ends with a one-cycle done pulse or a one-cycle error pulse. Moving the data itself is left to the consumer of the segment port.

Top module: `prd_chain_walker`

## Requirements
- R1: A descriptor's bits 31:0 appear on segAddr, and segBytes equals the bits 63:32 length count multiplied by 8, with no truncation even for a count of 0xFFFFFFFF.
- R2: Flag bit 5 (response bit 69) drives segWrite and flag bit 4 (bit 68) drives segOrdered. segMode carries the low 4 bits of the mode byte (bits 75:72), and the upper mode bits are ignored.
- R3: A start pulse while idle begins a walk at startAddr. After a non-final descriptor, the next descriptor is read from the address in its bits 127:96.
- R4: A start pulse while busy is ignored, and the walk in progress completes unchanged.
- R5: A descriptor with a zero length count produces no segment. The walk continues to its link, or ends with done if the descriptor is final.
- R6: An error pulse ends the walk with no segment from a descriptor in either of two cases: its buffer address is not 8-byte aligned, or it is non-final and its link is not 8-byte aligned. The link of a final descriptor (flag bit 7, bit 71) is not checked.
- R7: A start pulse with a startAddr that is not 8-byte aligned gives an error pulse and issues no descriptor read.
- R8: done is high for exactly one cycle. It follows acceptance of the final descriptor's segment, or evaluation of a final zero-length descriptor, and busy is low afterwards. done and err are never high together.
- R9: segValid stays high with stable segment fields until segReady is seen. rdValid stays high with a stable rdAddr until rdReady is seen. At most one descriptor read is outstanding.
- R10: After reset the walker is idle, with busy, done, err, rdValid and segValid all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| startAddr | input | 32 | Address of the first descriptor |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: walk finished normally |
| err | output | 1 | One-cycle pulse: walk aborted on alignment |
| rdValid | output | 1 | Descriptor read request |
| rdReady | input | 1 | Read request accepted |
| rdAddr | output | 32 | Descriptor address being read |
| rdRspValid | input | 1 | Descriptor data is valid |
| rdRspData | input | 128 | Descriptor, little-endian |
| segValid | output | 1 | Segment request valid |
| segReady | input | 1 | Data mover accepts the segment |
| segAddr | output | 32 | Segment buffer address |
| segBytes | output | 35 | Segment length in bytes |
| segWrite | output | 1 | Transfer is device-bound |
| segOrdered | output | 1 | Ordered-processing hint |
| segMode | output | 4 | DMA transfer mode for the segment |

## Verification
The assertions check the cycle-level properties on every cycle. These are the holding of both handshakes under back-pressure and the alignment of every read and segment address. They also cover the rule that no zero-byte segment is ever offered, the single-cycle and mutually exclusive done and error pulses, and the quiet ports while idle. Other behaviour only shows up in the bench scenarios. This includes the order and content of the segments a whole chain yields, the skipping of zero-length links, and the point in the chain where an alignment error stops the walk. The scenarios also show that the link of a final descriptor is never checked and that a second start during a walk is ignored.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_EVAL,
    ST_SEG
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;  // pointer <= startAddr
    logic loadDesc;   // capture descriptor fields from read data
    logic advance;    // pointer <= link of current descriptor
  } walkStrobe_t;

endpackage

// File: rtl/prd_walk_datapath.sv
module prd_walk_datapath
  import prd_walk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 32,
  parameter int MODE_W     = 4,
  parameter int ALIGN_BITS = 3,
  parameter int DESC_W     = 128
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  walkStrobe_t             strobe,
  input  logic [ADDR_W-1:0]       startAddr,
  input  logic [DESC_W-1:0]       rdRspData,
  output logic [ADDR_W-1:0]       descPtr,
  output logic [ADDR_W-1:0]       bufAddr,
  output logic [LEN_W+ALIGN_BITS-1:0] byteCount,
  output logic                    isWrite,
  output logic                    isOrdered,
  output logic [MODE_W-1:0]       modeOut,
  output logic                    isLast,
  output logic                    lenZero,
  output logic                    bufMisaligned,
  output logic                    linkMisaligned,
  output logic                    startMisaligned
);

  localparam int LEN_LO   = ADDR_W;
  localparam int FLAG_LO  = LEN_LO + LEN_W;
  localparam int MODE_LO  = FLAG_LO + 8;
  localparam int LINK_LO  = DESC_W - ADDR_W;
  localparam int BIT_ORD  = 4;
  localparam int BIT_WR   = 5;
  localparam int BIT_LAST = 7;

  logic [ADDR_W-1:0] linkPtr;
  logic [LEN_W-1:0]  lenField;
  logic [7:0]        flagByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr  <= '0;
      bufAddr  <= '0;
      lenField <= '0;
      flagByte <= '0;
      modeOut  <= '0;
      linkPtr  <= '0;
    end else begin
      if (strobe.loadStart) descPtr <= startAddr;
      else if (strobe.advance) descPtr <= linkPtr;
      if (strobe.loadDesc) begin
        bufAddr  <= rdRspData[ADDR_W-1:0];
        lenField <= rdRspData[LEN_LO +: LEN_W];
        flagByte <= rdRspData[FLAG_LO +: 8];
        modeOut  <= rdRspData[MODE_LO +: MODE_W];
        linkPtr  <= rdRspData[LINK_LO +: ADDR_W];
      end
    end
  end

  assign byteCount       = {lenField, {ALIGN_BITS{1'b0}}};
  assign isWrite         = flagByte[BIT_WR];
  assign isOrdered       = flagByte[BIT_ORD];
  assign isLast          = flagByte[BIT_LAST];
  assign lenZero         = (lenField == '0);
  assign bufMisaligned   = |bufAddr[ALIGN_BITS-1:0];
  assign linkMisaligned  = |linkPtr[ALIGN_BITS-1:0];
  assign startMisaligned = |startAddr[ALIGN_BITS-1:0];

endmodule

// File: rtl/prd_walk_ctrl.sv
module prd_walk_ctrl
  import prd_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        startMisaligned,
  input  logic        rdReady,
  input  logic        rdRspValid,
  input  logic        segReady,
  input  logic        isLast,
  input  logic        lenZero,
  input  logic        bufMisaligned,
  input  logic        linkMisaligned,
  output walkStrobe_t strobe,
  output logic        rdValid,
  output logic        segValid,
  output logic        busy,
  output logic        done,
  output logic        err
);

  walkState_t state, stateNext;
  logic doneNext, errNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    doneNext  = 1'b0;
    errNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (startMisaligned) errNext = 1'b1;
          else begin
            strobe.loadStart = 1'b1;
            stateNext        = ST_FETCH;
          end
        end
      end
      ST_FETCH: if (rdReady) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (rdRspValid) begin
          strobe.loadDesc = 1'b1;
          stateNext       = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (bufMisaligned || (!isLast && linkMisaligned)) begin
          errNext   = 1'b1;
          stateNext = ST_IDLE;
        end else if (!lenZero) begin
          stateNext = ST_SEG;
        end else if (isLast) begin
          doneNext  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobe.advance = 1'b1;
          stateNext      = ST_FETCH;
        end
      end
      ST_SEG: begin
        if (segReady) begin
          if (isLast) begin
            doneNext  = 1'b1;
            stateNext = ST_IDLE;
          end else begin
            strobe.advance = 1'b1;
            stateNext      = ST_FETCH;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
      err   <= errNext;
    end
  end

  assign rdValid  = (state == ST_FETCH);
  assign segValid = (state == ST_SEG);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/prd_chain_walker.sv
module prd_chain_walker
  import prd_walk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 32,
  parameter int MODE_W     = 4,
  parameter int ALIGN_BITS = 3,
  parameter int DESC_W     = 128,
  localparam int BYTES_W   = LEN_W + ALIGN_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [ADDR_W-1:0]  startAddr,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               rdValid,
  input  logic               rdReady,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic               rdRspValid,
  input  logic [DESC_W-1:0]  rdRspData,
  output logic               segValid,
  input  logic               segReady,
  output logic [ADDR_W-1:0]  segAddr,
  output logic [BYTES_W-1:0] segBytes,
  output logic               segWrite,
  output logic               segOrdered,
  output logic [MODE_W-1:0]  segMode
);

  walkStrobe_t strobe;
  logic isLast, lenZero, bufMis, linkMis, startMis;

  prd_walk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .startMisaligned(startMis),
    .rdReady(rdReady), .rdRspValid(rdRspValid), .segReady(segReady),
    .isLast(isLast), .lenZero(lenZero), .bufMisaligned(bufMis),
    .linkMisaligned(linkMis), .strobe(strobe), .rdValid(rdValid),
    .segValid(segValid), .busy(busy), .done(done), .err(err)
  );

  prd_walk_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MODE_W(MODE_W),
    .ALIGN_BITS(ALIGN_BITS), .DESC_W(DESC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .rdRspData(rdRspData), .descPtr(rdAddr), .bufAddr(segAddr),
    .byteCount(segBytes), .isWrite(segWrite), .isOrdered(segOrdered),
    .modeOut(segMode), .isLast(isLast), .lenZero(lenZero),
    .bufMisaligned(bufMis), .linkMisaligned(linkMis),
    .startMisaligned(startMis)
  );

endmodule

// File: rtl/prd_chain_walker_chk.sv
module prd_chain_walker_chk #(
  parameter int ADDR_W  = 32,
  parameter int BYTES_W = 35,
  parameter int MODE_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               busy,
  input logic               done,
  input logic               err,
  input logic               rdValid,
  input logic               rdReady,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic               segValid,
  input logic               segReady,
  input logic [ADDR_W-1:0]  segAddr,
  input logic [BYTES_W-1:0] segBytes,
  input logic               segWrite,
  input logic               segOrdered,
  input logic [MODE_W-1:0]  segMode
);

  p_seg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    segValid && !segReady |=> segValid && $stable(segAddr) && $stable(segBytes)
      && $stable(segWrite) && $stable(segOrdered) && $stable(segMode));

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdAddr));

  p_one_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && rdReady |=> !rdValid);

  p_rd_aligned_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> rdAddr[2:0] == 3'd0);

  p_seg_aligned_r6: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> segAddr[2:0] == 3'd0);

  p_seg_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> segBytes != '0);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(done && err));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !rdValid && !segValid);

endmodule

bind prd_chain_walker prd_chain_walker_chk #(
  .ADDR_W(ADDR_W), .BYTES_W(BYTES_W), .MODE_W(MODE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .err(err),
  .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr),
  .segValid(segValid), .segReady(segReady), .segAddr(segAddr),
  .segBytes(segBytes), .segWrite(segWrite), .segOrdered(segOrdered),
  .segMode(segMode)
);

// File: tb/prd_chain_walker_test.sv
module prd_chain_walker_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  startAddr = '0;
  logic         busy, done, err, rdValid, rdReady, segValid, segReady;
  logic [31:0]  rdAddr, segAddr;
  logic         rdRspValid = 1'b0;
  logic [127:0] rdRspData = '0;
  logic [34:0]  segBytes;
  logic         segWrite, segOrdered;
  logic [3:0]   segMode;

  always #2.5 clk = ~clk;  // 200 MHz

  prd_chain_walker uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .busy(busy), .done(done), .err(err), .rdValid(rdValid),
    .rdReady(rdReady), .rdAddr(rdAddr), .rdRspValid(rdRspValid),
    .rdRspData(rdRspData), .segValid(segValid), .segReady(segReady),
    .segAddr(segAddr), .segBytes(segBytes), .segWrite(segWrite),
    .segOrdered(segOrdered), .segMode(segMode)
  );

  int errors = 0;
  int checks = 0;

  // back-pressure pattern from a posedge counter: stable at the negedge
  logic [7:0] cyc = '0;
  logic       stall = 1'b0;
  always @(posedge clk) cyc <= cyc + 8'd1;
  assign segReady = stall ? cyc[0] : 1'b1;
  assign rdReady  = stall ? cyc[1] : 1'b1;

  // descriptor memory, one entry per 8-byte address
  logic [127:0] mem [32];

  function automatic logic [127:0] mkDesc(logic [31:0] a, logic [31:0] l,
      logic [7:0] f, logic [7:0] m, logic [31:0] nx);
    return {nx, 8'h00, 8'h5A, m, f, l, a};
  endfunction

  // read responder: handshake seen at a negedge completes at the next posedge
  logic       pend = 1'b0;
  logic [31:0] pendAddr = '0;
  int         readCnt = 0;
  always @(negedge clk) begin
    rdRspValid <= 1'b0;
    if (pend) begin
      rdRspValid <= 1'b1;
      rdRspData  <= mem[pendAddr[7:3]];
      pend       <= 1'b0;
    end
    if (rdValid && rdReady) begin
      pend     <= 1'b1;
      pendAddr <= rdAddr;
      readCnt  <= readCnt + 1;
    end
  end

  // segment / completion monitor
  int          segCnt = 0, doneCnt = 0, errCnt = 0;
  logic [63:0] byteSum = '0;
  logic [31:0] logAddr [8];
  logic        logWr [8];
  logic        logOrd [8];
  logic [3:0]  logMode [8];
  always @(negedge clk) begin
    if (segValid && segReady) begin
      if (segCnt < 8) begin
        logAddr[segCnt] <= segAddr;
        logWr[segCnt]   <= segWrite;
        logOrd[segCnt]  <= segOrdered;
        logMode[segCnt] <= segMode;
      end
      segCnt  <= segCnt + 1;
      byteSum <= byteSum + 64'(segBytes);
    end
    if (done) doneCnt <= doneCnt + 1;
    if (err)  errCnt  <= errCnt + 1;
  end

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    @(negedge clk);
    segCnt = 0; doneCnt = 0; errCnt = 0; byteSum = '0; readCnt = 0;
  endtask

  task automatic pulseStart(input logic [31:0] a);
    @(negedge clk);
    start = 1'b1; startAddr = a;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitEnd();
    int n = 0;
    while (doneCnt + errCnt == 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done_or_err");
    end
    repeat (4) @(negedge clk);
  endtask

  // vector table: start, stall, segs, bytes, done, err, reads
  localparam int NV = 8;
  localparam logic [31:0] V_START [NV] = '{32'h00, 32'h40, 32'h80, 32'hA8,
                                           32'hB8, 32'hC4, 32'h00, 32'hC8};
  localparam bit          V_STALL [NV] = '{0, 0, 0, 0, 0, 0, 1, 1};
  localparam int          V_SEGS  [NV] = '{3, 2, 1, 0, 0, 0, 3, 1};
  localparam logic [63:0] V_BYTES [NV] = '{64'd56, 64'd64, 64'd8, 64'd0,
                                           64'd0, 64'd0, 64'd56,
                                           64'h7_FFFF_FFF8};
  localparam bit          V_DONE  [NV] = '{1, 1, 0, 0, 1, 0, 1, 1};
  localparam bit          V_ERR   [NV] = '{0, 0, 1, 1, 0, 1, 0, 0};
  localparam int          V_READS [NV] = '{3, 3, 2, 1, 1, 0, 3, 1};

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = '0;
    // chain: write+ordered, ordered, last+write with upper mode bits and bad link
    mem[5'h00 >> 0] = mkDesc(32'h1000, 32'd4, 8'h30, 8'h05, 32'h10);
    mem[5'd2]  = mkDesc(32'h2000, 32'd2, 8'h10, 8'h02, 32'h20);
    mem[5'd4]  = mkDesc(32'h3008, 32'd1, 8'hA0, 8'hFA, 32'hDEAD_BEE3);
    // chain with zero-length middle link
    mem[5'd8]  = mkDesc(32'h4000, 32'd3, 8'h00, 8'h01, 32'h58);
    mem[5'd11] = mkDesc(32'h5000, 32'd0, 8'h00, 8'h01, 32'h68);
    mem[5'd13] = mkDesc(32'h6000, 32'd5, 8'h80, 8'h01, 32'h0);
    // misaligned buffer address in second descriptor
    mem[5'd16] = mkDesc(32'h7000, 32'd1, 8'h00, 8'h00, 32'h90);
    mem[5'd18] = mkDesc(32'h7004, 32'd2, 8'h00, 8'h00, 32'hA0);
    // misaligned link on non-final descriptor
    mem[5'd21] = mkDesc(32'h8000, 32'd1, 8'h00, 8'h00, 32'hB4);
    // single final zero-length
    mem[5'd23] = mkDesc(32'h0, 32'd0, 8'h80, 8'h00, 32'h0);
    // maximum length, final
    mem[5'd25] = mkDesc(32'h9000, 32'hFFFF_FFFF, 8'h80, 8'h03, 32'h0);

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 busy", 64'(busy), 64'd0);
    check("R10 rdValid", 64'(rdValid), 64'd0);
    check("R10 segValid", 64'(segValid), 64'd0);
    check("R10 done|err", 64'(done | err), 64'd0);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      stall = V_STALL[v];
      clearLog();
      pulseStart(V_START[v]);
      waitEnd();
      // R1 R3 R5 R6 R7 R9 per vector; R8 through single done count
      check($sformatf("R3/R5/R6 segs v%0d", v), 64'(segCnt), 64'(V_SEGS[v]));
      check($sformatf("R1 bytes v%0d", v), byteSum, V_BYTES[v]);
      check($sformatf("R8 done v%0d", v), 64'(doneCnt), 64'(V_DONE[v]));
      check($sformatf("R6/R7 err v%0d", v), 64'(errCnt), 64'(V_ERR[v]));
      check($sformatf("R7 reads v%0d", v), 64'(readCnt), 64'(V_READS[v]));
      check($sformatf("R8 busy low v%0d", v), 64'(busy), 64'd0);
      if (v == 0) begin
        check("R1 addr0", 64'(logAddr[0]), 64'h1000);
        check("R2 write0", 64'(logWr[0]), 64'd1);
        check("R2 ord0", 64'(logOrd[0]), 64'd1);
        check("R2 mode0", 64'(logMode[0]), 64'd5);
        check("R3 addr1", 64'(logAddr[1]), 64'h2000);
        check("R2 write1", 64'(logWr[1]), 64'd0);
        check("R2 mode2 upper bits ignored", 64'(logMode[2]), 64'hA);
        check("R2 ord2", 64'(logOrd[2]), 64'd0);
        check("R6 final link unchecked addr2", 64'(logAddr[2]), 64'h3008);
      end
      if (v == 1) begin
        check("R5 skip zero addr1", 64'(logAddr[1]), 64'h6000);
      end
    end

    // R4: second start during a walk is ignored
    stall = 1'b1;
    clearLog();
    pulseStart(32'h00);
    repeat (3) @(negedge clk);
    pulseStart(32'hB8);
    waitEnd();
    check("R4 segs", 64'(segCnt), 64'd3);
    check("R4 bytes", byteSum, 64'd56);
    check("R4 done", 64'(doneCnt), 64'd1);
    check("R4 first addr", 64'(logAddr[0]), 64'h1000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL global watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule